// File: doc/BRIEF.md
# Loop Exit Branch Predictor

This block recognises conditional branches that close a counted loop: the branch resolves in one direction a fixed number of times, then resolves the other way exactly once, and the pattern repeats. For every such branch it learns the exact trip length. It then predicts the single flip on the right execution instead of relying on a saturating bias counter. A small direct-mapped table indexed by the low bits of the branch PC holds, for each branch, its dominant direction, its learned trip length, its position in the current trip and a 2-bit confidence.

A fetch-side lookup presents a PC and gets back, in the same cycle, a hit flag, a predicted direction and a valid flag. The valid flag rises only once the same trip length has been seen on four exits in a row. A resolve-side update presents the PC and the actual outcome, and the table changes on the following clock edge. A chooser outside the block decides whether to use the prediction. The block supplies the valid flag only, and it does no repair of counts after wrong-path updates.

Top module: `loop_exit_pred`

## Requirements
- R1: `lk_hit` is 1 exactly when the entry at index `lk_pc[4:0]` is valid and its stored tag equals `lk_pc[31:5]`. The lookup is combinational and sees each update from the clock edge that applies it.
- R2: An update whose PC misses allocates the indexed entry. Its dominant direction becomes the update outcome (1 = taken), its position becomes 1, and its trip length and confidence become 0.
- R3: An update that hits with the outcome equal to the dominant direction advances the position by one.
- R4: An update that hits with the outcome opposite to the dominant direction ends the trip. The trip length observed is the position plus one, and the position returns to 0.
- R5: At the end of a trip, if the observed trip length equals the stored one, confidence goes up by one and stops at 3. Otherwise the stored trip length takes the observed value and confidence returns to 0.
- R6: `lk_valid` is 1 only when `lk_hit` is 1 and the entry's confidence is 3.
- R7: On a hit, `lk_dir` is the opposite of the dominant direction when position plus one equals the stored trip length, and the dominant direction otherwise. On a miss `lk_dir` is 0.
- R8: A dominant-direction update to an entry whose position is already 254 invalidates that entry.
- R9: A missing PC that shares an index with a valid entry replaces that entry, so the former PC misses afterwards.
- R10: Reset invalidates every entry. While no entry is valid, `lk_hit`, `lk_valid` and `lk_dir` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | PC to predict |
| lk_hit | output | 1 | Table holds this PC |
| lk_valid | output | 1 | Prediction is confident |
| lk_dir | output | 1 | Predicted direction, 1 = taken |
| up_en | input | 1 | Resolved outcome present |
| up_pc | input | 32 | PC of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
Loops are swept over every trip length from 2 to 13 and over both dominant directions, each for six trips. This separates the learning phase from the confident phase and shows that the flip is placed on the exact last execution rather than one early or late. A loop that suddenly runs two extra iterations shows that the learned length is dropped and confidence cleared. A trip of 255 executions and an unbroken run of 255 dominant outcomes separate the largest storable trip from the overflow that invalidates. Two PCs that share an index show that replacement happens by tag.

// File: rtl/loop_exit_pred.sv
module loop_exit_pred #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 5,
  parameter int CNT_W  = 8,
  parameter int CONF_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_valid,
  output logic            lk_dir,
  input  logic            up_en,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W;
  localparam logic [CNT_W-1:0]  CNT_TOP  = CNT_W'((1 << CNT_W) - 2);
  localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};

  logic              v_q    [ENTRIES];
  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic              dom_q  [ENTRIES];
  logic [CNT_W-1:0]  lim_q  [ENTRIES];
  logic [CNT_W-1:0]  cnt_q  [ENTRIES];
  logic [CONF_W-1:0] conf_q [ENTRIES];

  wire [IDX_W-1:0] lk_idx = lk_pc[IDX_W-1:0];
  wire [TAG_W-1:0] lk_tag = lk_pc[PC_W-1:IDX_W];
  wire             lk_flip = (cnt_q[lk_idx] + 1'b1) == lim_q[lk_idx];

  assign lk_hit   = v_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_dir   = lk_hit && (dom_q[lk_idx] ^ lk_flip);
  assign lk_valid = lk_hit && (conf_q[lk_idx] == CONF_MAX);

  wire [IDX_W-1:0] up_idx   = up_pc[IDX_W-1:0];
  wire [TAG_W-1:0] up_tag   = up_pc[PC_W-1:IDX_W];
  wire             up_hit   = v_q[up_idx] && (tag_q[up_idx] == up_tag);
  wire             up_exit  = up_taken != dom_q[up_idx];
  wire [CNT_W-1:0] up_trip  = cnt_q[up_idx] + 1'b1;
  wire             up_match = up_trip == lim_q[up_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        v_q[i]    <= 1'b0;
        tag_q[i]  <= '0;
        dom_q[i]  <= 1'b0;
        lim_q[i]  <= '0;
        cnt_q[i]  <= '0;
        conf_q[i] <= '0;
      end
    end else if (up_en) begin
      if (!up_hit) begin
        v_q[up_idx]    <= 1'b1;
        tag_q[up_idx]  <= up_tag;
        dom_q[up_idx]  <= up_taken;
        lim_q[up_idx]  <= '0;
        cnt_q[up_idx]  <= CNT_W'(1);
        conf_q[up_idx] <= '0;
      end else if (!up_exit) begin
        if (cnt_q[up_idx] == CNT_TOP) v_q[up_idx] <= 1'b0;
        else cnt_q[up_idx] <= cnt_q[up_idx] + 1'b1;
      end else begin
        cnt_q[up_idx] <= '0;
        if (up_match) begin
          if (conf_q[up_idx] != CONF_MAX) conf_q[up_idx] <= conf_q[up_idx] + 1'b1;
        end else begin
          lim_q[up_idx]  <= up_trip;
          conf_q[up_idx] <= '0;
        end
      end
    end
  end

  AST_VALID_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> lk_hit); // R6

  AST_ALLOC_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && !up_hit) |=> (v_q[$past(up_idx)] && tag_q[$past(up_idx)] == $past(up_tag)
                            && cnt_q[$past(up_idx)] == CNT_W'(1) && conf_q[$past(up_idx)] == '0)); // R2

  AST_EXIT_CLEARS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && up_hit && up_exit) |=> (cnt_q[$past(up_idx)] == '0)); // R4

  AST_MISMATCH_RELEARNS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && up_hit && up_exit && !up_match) |=>
      (conf_q[$past(up_idx)] == '0 && lim_q[$past(up_idx)] == $past(up_trip))); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && up_hit && !up_exit && cnt_q[up_idx] == CNT_TOP) |=> !v_q[$past(up_idx)]); // R8

  AST_DOM_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && up_hit && !up_exit && cnt_q[up_idx] != CNT_TOP) |=>
      (cnt_q[$past(up_idx)] == $past(cnt_q[up_idx]) + 1'b1)); // R3
endmodule

// File: tb/test_loop_exit_pred.sv
module test_loop_exit_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic [31:0] up_pc = '0;
  logic        up_en = 1'b0;
  logic        up_taken = 1'b0;
  logic        lk_hit, lk_valid, lk_dir;
  logic        o_hit, o_valid, o_dir;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  loop_exit_pred i_loop_exit_pred (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_valid(lk_valid),
    .lk_dir(lk_dir), .up_en(up_en), .up_pc(up_pc), .up_taken(up_taken));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic probe(input logic [31:0] pc);
    @(negedge clk);
    up_en = 1'b0;
    lk_pc = pc;
    #1;
    o_hit = lk_hit; o_valid = lk_valid; o_dir = lk_dir;
  endtask

  task automatic step(input logic [31:0] pc, input logic taken);
    @(negedge clk);
    lk_pc = pc; up_pc = pc; up_taken = taken; up_en = 1'b1;
    #1;
    o_hit = lk_hit; o_valid = lk_valid; o_dir = lk_dir;
    @(posedge clk);
    #1 up_en = 1'b0;
  endtask

  // fresh PC, n dominant outcomes then one exit, repeated
  task automatic run_loop(input logic [31:0] pc, input logic dom, input int n, input int periods);
    for (int p = 0; p < periods; p++) begin
      for (int k = 1; k <= n + 1; k++) begin
        step(pc, (k == n + 1) ? !dom : dom);
        if (p == 0 && k == 1) chk("R1 R2 fresh pc misses", o_hit, 1'b0);
        else chk("R1 allocated pc hits", o_hit, 1'b1);
        chk("R5 R6 valid after four matching exits", o_valid, p >= 4);
        if (p >= 4) chk("R3 R4 R7 flip on last execution", o_dir, (k == n + 1) ? !dom : dom);
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      probe(32'(i * 37));
      chk("R10 reset hit", o_hit, 1'b0);
      chk("R10 reset valid", o_valid, 1'b0);
      chk("R10 reset dir", o_dir, 1'b0);
    end

    for (int n = 1; n <= 12; n++)
      for (int d = 0; d < 2; d++)
        run_loop(32'(n * 2 + d), d[0], n, 6);

    probe(32'd5);
    chk("R1 earlier entry kept", o_hit, 1'b1);
    chk("R6 earlier entry confident", o_valid, 1'b1);

    step(32'h23, 1'b1);
    chk("R9 colliding pc misses", o_hit, 1'b0);
    probe(32'h3);
    chk("R9 evicted pc misses", o_hit, 1'b0);
    probe(32'h23);
    chk("R2 new pc allocated", o_hit, 1'b1);
    chk("R2 new entry not confident", o_valid, 1'b0);

    run_loop(32'h11E, 1'b1, 3, 6);
    for (int k = 1; k <= 6; k++) begin
      step(32'h11E, (k == 6) ? 1'b0 : 1'b1);
      if (k == 4) begin
        chk("R7 flip predicted at learned length", o_dir, 1'b0);
        chk("R6 still confident before exit", o_valid, 1'b1);
      end
    end
    probe(32'h11E);
    chk("R5 mismatch clears confidence", o_valid, 1'b0);
    chk("R5 entry still present", o_hit, 1'b1);

    for (int k = 1; k <= 254; k++) step(32'h5F, 1'b1);
    chk("R3 entry alive at position 254", o_hit, 1'b1);
    step(32'h5F, 1'b1);
    chk("R8 hit before overflow update", o_hit, 1'b1);
    probe(32'h5F);
    chk("R8 overflow invalidates", o_hit, 1'b0);
    chk("R8 overflow valid low", o_valid, 1'b0);

    run_loop(32'h7C, 1'b0, 254, 6);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule